// File: doc/BRIEF.md
# Keypad Arbiter with Timed Two-Key Combination

This block sits between a debounced key matrix of up to 64 keys and an infrared frame transmitter. It watches the key-pressed vector on every millisecond tick and decides whether a frame should go out and which 8-bit data code it carries. It handles three cases: a single key press, two keys that overlap, and three or more keys at once. When two keys overlap, the outcome depends on how far apart the two presses were, measured in ticks from the first press.

The first frame goes out a fixed number of ticks after a lone press. Frames then repeat at a fixed period for as long as that key stays down. One designated special key followed, after a long enough gap, by one of three partner keys produces a combined code. That code is the partner's code with bit D5 set. A continuous-mode input turns this combination off. Bit D7 of every code follows a static select input.

The transmitter receives a one-cycle `frame_start` pulse and a `frame_hold` level that stays high while frames may continue. It also receives `data_code`, which is valid whenever `frame_start` is high.

Top module: `kp_arbiter`

## Requirements
- R1: A press of a single key, with no other key down, is seen on a tick. Exactly 36 ticks later, `frame_start` pulses for one clock in the cycle after that tick. `frame_hold` rises at the same time.
- R2: While that key stays the only key down, `frame_start` repeats every 108 ticks after the first frame, and `frame_hold` stays high.
- R3: A second key arriving at most 36 ticks after the first suppresses all frames until every key has been released, whichever key was first.
- R4: A second key arriving 37 to 125 ticks after the first stops transmission: only the first frame goes out, and `frame_hold` falls.
- R5: The special key is index 20 and the partners are indices 21, 22 and 23. If the special key is down first and a partner arrives 126 or more ticks later, a frame goes out on that tick. Its code is the partner's code with D5 = 1, and it repeats every 108 ticks while both keys stay down.
- R6: If a partner key is down first and the special key follows, no combined code is produced. Transmission stops after the partner's own frames.
- R7: On any tick that sees three or more keys down, no frame starts, and `frame_hold` is low after that tick.
- R8: Code layout: D4..D0 = key index bits 4..0; D6 = 1 for indices 0 to 31 and 0 for indices 32 to 63; D5 = 0 for any single-key frame.
- R9: D7 of every code is the inverse of `sel_level`: high gives 0 and low gives 1.
- R10: With `cont_mode` high the two-key combination is disabled. The late partner press stops transmission instead, and D5 is never 1.
- R11: On a tick that sees no key down, `frame_hold` falls and the arbiter returns to idle. A new press is then timed from its own tick, with no lock-out.
- R12: After reset, `frame_start`, `frame_hold` and `data_code` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse once per millisecond |
| keys_down | input | NKEYS | Debounced key-pressed vector, bit i = key index i |
| sel_level | input | 1 | Static select level for D7 |
| cont_mode | input | 1 | High disables the two-key combination |
| frame_start | output | 1 | One-cycle request to send a frame |
| frame_hold | output | 1 | High while frames may continue |
| data_code | output | 8 | Data code for the frame being started |

## Verification
A table of press patterns drives the arbiter. Each pattern is a first key, an optional second key, the tick on which the second key arrives, and how long the keys are held. The arrival ticks 36 and 37, and 125 and 126, sit on either side of each window edge. They separate a full block from a single frame, and a stop from a combined code. Reversing the order of the special and partner keys, and turning on continuous mode, show whether the combination is gated correctly. Keys in both halves of the keypad and both select levels fix the D6 and D7 bits. Directed runs then check the exact tick of the first frame, three-key lock-out during an active combination, and re-pressing a key right after release.

// File: rtl/kp_pkg.sv
// Package: shared types and the data-code former for the keypad arbiter.
// Assumes key indices fit in 6 bits (at most 64 keys).
package kp_pkg;
    localparam int KP_IDX_W  = 6;
    localparam int KP_CODE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_SEND,
        ST_DUAL,
        ST_HALT,
        ST_BLOCK
    } kp_state_e;

    // Build the 8-bit code: {~sel, ~half, dual, low five index bits}.
    function automatic logic [KP_CODE_W-1:0] kp_form_code(
        input logic [KP_IDX_W-1:0] idx,
        input logic                dual,
        input logic                sel_hi
    );
        return {~sel_hi, ~idx[KP_IDX_W-1], dual, idx[4:0]};
    endfunction
endpackage

// File: rtl/kp_scan.sv
// kp_scan: combinational survey of the key vector.
// It gives the number of keys down (the count saturates at 3), the lowest
// key index down, the lowest key index down other than the tracked first
// key, and whether the tracked first and mate keys are still held.
// Assumes NKEYS <= 64.
module kp_scan #(
    parameter int NKEYS = 64,
    parameter int IDX_W = 6
) (
    input  logic [NKEYS-1:0] keys,
    input  logic [IDX_W-1:0] first_idx,
    input  logic [IDX_W-1:0] mate_idx,
    output logic [1:0]       count,
    output logic [IDX_W-1:0] low_idx,
    output logic [IDX_W-1:0] other_idx,
    output logic             first_held,
    output logic             mate_held
);
    localparam int SPAN = 1 << IDX_W;

    logic [NKEYS-1:0] others;
    logic [SPAN-1:0]  padded;

    // One mask bit per key: the key is down and is not the tracked first key.
    for (genvar g = 0; g < NKEYS; g++) begin : g_mask
        assign others[g] = keys[g] && (first_idx != IDX_W'(g));
    end

    // Zero-extend the key vector so any index can be looked up safely.
    assign padded = SPAN'(keys);

    // Saturating population count (0, 1, 2, 3-or-more).
    always_comb begin
        count = 2'd0;
        for (int i = 0; i < NKEYS; i++) begin
            if (keys[i] && count != 2'd3) count = count + 2'd1;
        end
    end

    // Lowest index among all keys down and among the other keys.
    always_comb begin
        low_idx   = '0;
        other_idx = '0;
        for (int i = NKEYS - 1; i >= 0; i--) begin
            if (keys[i])   low_idx   = IDX_W'(i);
            if (others[i]) other_idx = IDX_W'(i);
        end
    end

    // Presence of the two tracked keys.
    always_comb begin
        first_held = padded[first_idx];
        mate_held  = padded[mate_idx];
    end
endmodule

// File: rtl/kp_satcnt.sv
// kp_satcnt: tick counter with synchronous clear and saturation at MAXV.
// Clear has priority over increment. Assumes W is wide enough for MAXV + 1.
module kp_satcnt #(
    parameter int MAXV = 126,
    parameter int W    = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] value
);
    // Count up on request, hold at the ceiling, reset to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)                    value <= '0;
        else if (inc && value != W'(MAXV))    value <= value + W'(1);
    end
endmodule

// File: rtl/kp_fsm.sv
// kp_fsm: arbitration state machine, evaluated only on millisecond ticks.
// It tracks the first key and the combination mate, and requests a frame
// (fire) together with the index and the dual flag to encode.
// Assumes the age and repeat counters are driven by its clr/inc outputs.
module kp_fsm
    import kp_pkg::*;
#(
    parameter int IDX_W       = 6,
    parameter int AGE_W       = 8,
    parameter int REP_W       = 8,
    parameter int ARM_MS      = 36,
    parameter int LATE_MS     = 126,
    parameter int REP_MS      = 108,
    parameter int SPECIAL_KEY = 20,
    parameter int PARTNER_LO  = 21,
    parameter int PARTNERS    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cont_mode,
    input  logic [1:0]       count,
    input  logic [IDX_W-1:0] low_idx,
    input  logic [IDX_W-1:0] other_idx,
    input  logic             first_held,
    input  logic             mate_held,
    input  logic [AGE_W-1:0] age,
    input  logic [REP_W-1:0] rep,
    output kp_state_e        state,
    output logic [IDX_W-1:0] first_idx,
    output logic [IDX_W-1:0] mate_idx,
    output logic             age_clr,
    output logic             age_inc,
    output logic             rep_clr,
    output logic             rep_inc,
    output logic             fire,
    output logic             fire_dual,
    output logic [IDX_W-1:0] fire_idx
);
    localparam logic [IDX_W-1:0] SPEC_I = IDX_W'(SPECIAL_KEY);
    localparam logic [IDX_W-1:0] PLO_I  = IDX_W'(PARTNER_LO);
    localparam logic [IDX_W-1:0] PHI_I  = IDX_W'(PARTNER_LO + PARTNERS - 1);

    kp_state_e        st_d;
    logic [IDX_W-1:0] first_d, mate_d;
    logic             arm_due, late, rep_due, combo_ok;

    // Window and period decisions taken from the counters.
    always_comb begin
        arm_due  = (age + AGE_W'(1)) == AGE_W'(ARM_MS);
        late     = (age + AGE_W'(1)) >= AGE_W'(LATE_MS);
        rep_due  = (rep + REP_W'(1)) == REP_W'(REP_MS);
        combo_ok = (first_idx == SPEC_I) && (other_idx >= PLO_I)
                   && (other_idx <= PHI_I) && !cont_mode;
    end

    // Next-state and counter-control logic.
    always_comb begin
        st_d      = state;
        first_d   = first_idx;
        mate_d    = mate_idx;
        age_clr   = 1'b0;
        age_inc   = 1'b0;
        rep_clr   = 1'b0;
        rep_inc   = 1'b0;
        fire      = 1'b0;
        fire_dual = 1'b0;
        fire_idx  = first_idx;
        if (tick) begin
            unique case (state)
                ST_IDLE: begin
                    age_clr = 1'b1;
                    rep_clr = 1'b1;
                    if (count == 2'd1) begin
                        first_d = low_idx;
                        st_d    = ST_ARM;
                    end
                end
                ST_ARM: begin
                    if (count == 2'd0)      st_d = ST_IDLE;
                    else if (count != 2'd1) st_d = ST_BLOCK;
                    else if (!first_held) begin
                        first_d = low_idx;
                        age_clr = 1'b1;
                    end else if (arm_due) begin
                        fire    = 1'b1;
                        age_inc = 1'b1;
                        rep_clr = 1'b1;
                        st_d    = ST_SEND;
                    end else begin
                        age_inc = 1'b1;
                    end
                end
                ST_SEND: begin
                    if (count == 2'd0)      st_d = ST_IDLE;
                    else if (count == 2'd3) st_d = ST_BLOCK;
                    else if (count == 2'd2) begin
                        if (first_held && late && combo_ok) begin
                            mate_d    = other_idx;
                            fire      = 1'b1;
                            fire_dual = 1'b1;
                            fire_idx  = other_idx;
                            rep_clr   = 1'b1;
                            st_d      = ST_DUAL;
                        end else begin
                            st_d = ST_HALT;
                        end
                    end else if (!first_held) begin
                        first_d = low_idx;
                        age_clr = 1'b1;
                        st_d    = ST_ARM;
                    end else begin
                        age_inc = 1'b1;
                        if (rep_due) begin
                            fire    = 1'b1;
                            rep_clr = 1'b1;
                        end else begin
                            rep_inc = 1'b1;
                        end
                    end
                end
                ST_DUAL: begin
                    if (count == 2'd0)      st_d = ST_IDLE;
                    else if (count == 2'd3) st_d = ST_BLOCK;
                    else if (count == 2'd2 && first_held && mate_held && !cont_mode) begin
                        if (rep_due) begin
                            fire      = 1'b1;
                            fire_dual = 1'b1;
                            fire_idx  = mate_idx;
                            rep_clr   = 1'b1;
                        end else begin
                            rep_inc = 1'b1;
                        end
                    end else begin
                        st_d = ST_HALT;
                    end
                end
                ST_HALT: begin
                    if (count == 2'd0)      st_d = ST_IDLE;
                    else if (count == 2'd3) st_d = ST_BLOCK;
                end
                default: begin
                    if (count == 2'd0) st_d = ST_IDLE;
                end
            endcase
        end
    end

    // State and tracked-key registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            first_idx <= '0;
            mate_idx  <= '0;
        end else begin
            state     <= st_d;
            first_idx <= first_d;
            mate_idx  <= mate_d;
        end
    end
endmodule

// File: rtl/kp_arbiter.sv
// kp_arbiter: top of the keypad arbiter. It joins the key survey, the two
// tick counters and the state machine, and registers the frame request,
// the hold level and the data code.
// Assumes keys_down is debounced and ms_tick is a one-cycle pulse.
module kp_arbiter
    import kp_pkg::*;
#(
    parameter int NKEYS       = 64,
    parameter int ARM_MS      = 36,
    parameter int LATE_MS     = 126,
    parameter int REP_MS      = 108,
    parameter int SPECIAL_KEY = 20,
    parameter int PARTNER_LO  = 21,
    parameter int PARTNERS    = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ms_tick,
    input  logic [NKEYS-1:0]     keys_down,
    input  logic                 sel_level,
    input  logic                 cont_mode,
    output logic                 frame_start,
    output logic                 frame_hold,
    output logic [KP_CODE_W-1:0] data_code
);
    localparam int IDX_W = KP_IDX_W;
    localparam int AGE_W = $clog2(LATE_MS + 2);
    localparam int REP_W = $clog2(REP_MS + 2);

    logic [1:0]       count;
    logic [IDX_W-1:0] low_idx, other_idx, first_idx, mate_idx, fire_idx;
    logic             first_held, mate_held;
    logic             age_clr, age_inc, rep_clr, rep_inc, fire, fire_dual;
    logic [AGE_W-1:0] age;
    logic [REP_W-1:0] rep;
    kp_state_e        state;

    kp_scan #(.NKEYS(NKEYS), .IDX_W(IDX_W)) u_scan (
        .keys       (keys_down),
        .first_idx  (first_idx),
        .mate_idx   (mate_idx),
        .count      (count),
        .low_idx    (low_idx),
        .other_idx  (other_idx),
        .first_held (first_held),
        .mate_held  (mate_held)
    );

    kp_satcnt #(.MAXV(LATE_MS), .W(AGE_W)) u_age (
        .clk (clk), .rst_n (rst_n), .clr (age_clr), .inc (age_inc), .value (age)
    );

    kp_satcnt #(.MAXV(REP_MS), .W(REP_W)) u_rep (
        .clk (clk), .rst_n (rst_n), .clr (rep_clr), .inc (rep_inc), .value (rep)
    );

    kp_fsm #(
        .IDX_W (IDX_W), .AGE_W (AGE_W), .REP_W (REP_W),
        .ARM_MS (ARM_MS), .LATE_MS (LATE_MS), .REP_MS (REP_MS),
        .SPECIAL_KEY (SPECIAL_KEY), .PARTNER_LO (PARTNER_LO), .PARTNERS (PARTNERS)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (ms_tick),
        .cont_mode  (cont_mode),
        .count      (count),
        .low_idx    (low_idx),
        .other_idx  (other_idx),
        .first_held (first_held),
        .mate_held  (mate_held),
        .age        (age),
        .rep        (rep),
        .state      (state),
        .first_idx  (first_idx),
        .mate_idx   (mate_idx),
        .age_clr    (age_clr),
        .age_inc    (age_inc),
        .rep_clr    (rep_clr),
        .rep_inc    (rep_inc),
        .fire       (fire),
        .fire_dual  (fire_dual),
        .fire_idx   (fire_idx)
    );

    // Hold is high while the arbiter is in a transmitting state.
    assign frame_hold = (state == ST_SEND) || (state == ST_DUAL);

    // Register the frame request and the code that goes with it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_start <= 1'b0;
            data_code   <= '0;
        end else begin
            frame_start <= fire;
            if (fire) data_code <= kp_form_code(fire_idx, fire_dual, sel_level);
        end
    end
endmodule

// File: rtl/kp_arbiter_chk.sv
// kp_arbiter_chk: temporal properties of the keypad arbiter, seen at its
// ports. It is bound to every kp_arbiter instance.
module kp_arbiter_chk #(
    parameter int NKEYS = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ms_tick,
    input logic [NKEYS-1:0] keys_down,
    input logic             sel_level,
    input logic             cont_mode,
    input logic             frame_start,
    input logic             frame_hold,
    input logic [7:0]       data_code
);
    // R1: a frame request only follows a tick.
    p_start_after_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> $past(ms_tick));

    // R2: a frame request always comes with hold high.
    p_start_with_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> frame_hold);

    // R7: three or more keys down on a tick give no frame and no hold.
    p_crowd_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ms_tick && $countones(keys_down) >= 3) |=> (!frame_start && !frame_hold));

    // R9: D7 is the inverse of the select level.
    p_sel_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (data_code[7] == !$past(sel_level)));

    // R10: continuous mode never yields D5 = 1.
    p_cont_no_dual_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && $past(cont_mode)) |-> !data_code[5]);

    // R11: a tick with no key down drops hold and gives no frame.
    p_release_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ms_tick && keys_down == '0) |=> (!frame_hold && !frame_start));
endmodule

bind kp_arbiter kp_arbiter_chk #(.NKEYS(NKEYS)) u_kp_arbiter_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ms_tick     (ms_tick),
    .keys_down   (keys_down),
    .sel_level   (sel_level),
    .cont_mode   (cont_mode),
    .frame_start (frame_start),
    .frame_hold  (frame_hold),
    .data_code   (data_code)
);

// File: tb/kp_arbiter_bench.sv
module kp_arbiter_bench;
    localparam int NK = 64;

    typedef struct packed {
        logic [7:0]  a;
        logic [7:0]  b;
        logic [15:0] dly;
        logic [15:0] tot;
        logic        cont;
        logic        sel;
        logic [7:0]  n;
        logic [7:0]  c0;
        logic [7:0]  cl;
        logic        hold;
    } vec_t;

    // a, b (FF = none), second-key tick, ticks held, cont, sel,
    // frames, first code, last code, hold before release
    localparam vec_t VECS [13] = '{
        '{8'd5,  8'hFF, 16'd0,   16'd40,  1'b0, 1'b1, 8'd1, 8'h45, 8'h45, 1'b1},
        '{8'd40, 8'hFF, 16'd0,   16'd150, 1'b0, 1'b0, 8'd2, 8'h88, 8'h88, 1'b1},
        '{8'd5,  8'd10, 16'd20,  16'd100, 1'b0, 1'b1, 8'd0, 8'h00, 8'h00, 1'b0},
        '{8'd5,  8'd10, 16'd60,  16'd200, 1'b0, 1'b1, 8'd1, 8'h45, 8'h45, 1'b0},
        '{8'd20, 8'd21, 16'd126, 16'd250, 1'b0, 1'b1, 8'd3, 8'h54, 8'h75, 1'b1},
        '{8'd20, 8'd21, 16'd126, 16'd250, 1'b1, 1'b1, 8'd1, 8'h54, 8'h54, 1'b0},
        '{8'd21, 8'd20, 16'd130, 16'd200, 1'b0, 1'b1, 8'd1, 8'h55, 8'h55, 1'b0},
        '{8'd20, 8'd30, 16'd130, 16'd200, 1'b0, 1'b1, 8'd1, 8'h54, 8'h54, 1'b0},
        '{8'd20, 8'd21, 16'd36,  16'd100, 1'b0, 1'b1, 8'd0, 8'h00, 8'h00, 1'b0},
        '{8'd20, 8'd21, 16'd37,  16'd100, 1'b0, 1'b1, 8'd1, 8'h54, 8'h54, 1'b0},
        '{8'd20, 8'd21, 16'd125, 16'd250, 1'b0, 1'b1, 8'd1, 8'h54, 8'h54, 1'b0},
        '{8'd63, 8'hFF, 16'd0,   16'd35,  1'b0, 1'b1, 8'd0, 8'h00, 8'h00, 1'b0},
        '{8'd20, 8'd23, 16'd200, 16'd320, 1'b0, 1'b0, 8'd4, 8'hD4, 8'hF7, 1'b1}
    };
    localparam string VREQ [13] = '{"R1 R8", "R2 R8 R9", "R3", "R4", "R5",
        "R10", "R6", "R6", "R3", "R4", "R4", "R1", "R5 R9"};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ms_tick = 1'b0;
    logic [NK-1:0] keys_down = '0;
    logic          sel_level = 1'b1;
    logic          cont_mode = 1'b0;
    logic          frame_start, frame_hold;
    logic [7:0]    data_code;

    int  n_chk = 0, n_fail = 0, nfr = 0;
    logic [7:0] firstc = 8'h00, lastc = 8'h00;
    bit  finished = 0;

    always #5 clk = ~clk;

    kp_arbiter u_kp_arbiter (
        .clk (clk), .rst_n (rst_n), .ms_tick (ms_tick), .keys_down (keys_down),
        .sel_level (sel_level), .cont_mode (cont_mode),
        .frame_start (frame_start), .frame_hold (frame_hold), .data_code (data_code)
    );

    // Frame monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && frame_start) begin
            nfr = nfr + 1;
            lastc = data_code;
            if (nfr == 1) firstc = data_code;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_tick();
        @(negedge clk) ms_tick = 1'b1;
        @(negedge clk) ms_tick = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic release_all(input string req);
        keys_down = '0;
        do_tick();
        chk(frame_hold == 1'b0, req, int'(frame_hold), 0);
        do_tick();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R12: reset state
        repeat (3) @(negedge clk);
        chk(frame_start == 1'b0 && frame_hold == 1'b0 && data_code == 8'h00, "R12",
            {frame_start, frame_hold, data_code}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(frame_start == 1'b0 && frame_hold == 1'b0, "R12", {frame_start, frame_hold}, 0);

        // Table walk
        for (int v = 0; v < 13; v++) begin
            cont_mode = VECS[v].cont;
            sel_level = VECS[v].sel;
            nfr = 0;
            keys_down = '0;
            keys_down[VECS[v].a[5:0]] = 1'b1;
            do_tick();
            for (int t = 1; t <= int'(VECS[v].tot); t++) begin
                if (t == int'(VECS[v].dly) && VECS[v].b != 8'hFF) keys_down[VECS[v].b[5:0]] = 1'b1;
                do_tick();
            end
            chk(nfr == int'(VECS[v].n), VREQ[v], nfr, int'(VECS[v].n));
            chk(frame_hold == VECS[v].hold, VREQ[v], int'(frame_hold), int'(VECS[v].hold));
            if (VECS[v].n != 8'd0) begin
                chk(firstc == VECS[v].c0, VREQ[v], int'(firstc), int'(VECS[v].c0));
                chk(lastc == VECS[v].cl, VREQ[v], int'(lastc), int'(VECS[v].cl));
            end
            release_all("R11");
        end
        cont_mode = 1'b0;
        sel_level = 1'b1;

        // R1: first frame on exactly the 36th tick after the press tick
        nfr = 0;
        keys_down[7] = 1'b1;
        do_tick();
        repeat (35) do_tick();
        chk(nfr == 0, "R1", nfr, 0);
        do_tick();
        chk(nfr == 1, "R1", nfr, 1);
        chk(lastc == 8'h47, "R1 R8", int'(lastc), 8'h47);
        chk(frame_hold == 1'b1, "R1", int'(frame_hold), 1);
        release_all("R11");

        // R7: three keys at once give nothing
        nfr = 0;
        keys_down[1] = 1'b1; keys_down[2] = 1'b1; keys_down[3] = 1'b1;
        repeat (40) do_tick();
        chk(nfr == 0 && frame_hold == 1'b0, "R7", nfr, 0);
        release_all("R11");

        // R7: a third key during a running combination stops it
        nfr = 0;
        keys_down[20] = 1'b1;
        do_tick();
        for (int t = 1; t <= 130; t++) begin
            if (t == 126) keys_down[22] = 1'b1;
            do_tick();
        end
        chk(nfr == 2 && lastc == 8'h76, "R5", {nfr, lastc}, {32'd2, 8'h76});
        keys_down[40] = 1'b1;
        do_tick();
        chk(frame_hold == 1'b0, "R7", int'(frame_hold), 0);
        repeat (120) do_tick();
        chk(nfr == 2, "R7", nfr, 2);
        release_all("R11");

        // R11: re-press right after release is timed afresh
        nfr = 0;
        keys_down[9] = 1'b1;
        do_tick();
        repeat (20) do_tick();
        keys_down = '0;
        do_tick();
        keys_down[9] = 1'b1;
        do_tick();
        repeat (35) do_tick();
        chk(nfr == 0, "R11", nfr, 0);
        do_tick();
        chk(nfr == 1 && lastc == 8'h49, "R11", {nfr, lastc}, {32'd1, 8'h49});
        release_all("R11");

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule